// File: doc/BRIEF.md
# Trap Entry and Delegation Controller

This block carries out the architectural state change that happens when a hart takes an exception or an interrupt. The pipeline raises a one-cycle trap strobe together with the cause word, the PC of the faulting instruction and an optional bad-address value. In that same cycle the block returns the redirect PC, the new privilege level and the rewritten status word, each with its own write strobe, for the surrounding CSR file to commit. On the rising edge that ends the cycle it latches the cause, exception PC and bad-address registers of the level that handles the trap.

The handling level is chosen from the cause word. If the top bit of the cause is set, the interrupt delegation mask is used. Otherwise the exception delegation mask is used. The lower bits of the cause index that mask. A trap goes to supervisor level only when the hart runs at supervisor level or below. All other traps go to machine level.

A software breakpoint can be diverted into debug mode by per-privilege enable bits. While a debug cause is recorded, any later trap only jumps to the debug exception address. The debug ROM entry and exception addresses are parameters.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset every latched register output (scause, sepc, sbadaddr, mcause, mepc, mbadaddr, dpc, debug cause, debug privilege) is zero, and with no trap both write strobes are low.
- R2: A trap whose cause has the top bit clear and value 3 (breakpoint), with ebreak_en_i[priv_i] set, gives pc_o = DBG_ROM_BASE, priv_we_o = 1 with priv_o = 3, status_we_o = 0. On the edge it latches debug cause 1, debug privilege = priv_i and dpc = epc_i, and it leaves the supervisor and machine registers alone. This check takes precedence over R3.
- R3: When the debug cause is nonzero and R2 does not apply, a trap gives pc_o = DBG_ROM_EXC with both write strobes low, and no latched register changes.
- R4: When the cause top bit is set, bit cause[XLEN-2:0] of mideleg_i is consulted. When it is clear, bit cause of medeleg_i is consulted. An index of XLEN or more counts as not delegated.
- R5: A trap is handled at supervisor level only if priv_i is 0 (U) or 1 (S) and the consulted delegation bit is 1. At priv_i 2 or 3 it is always handled at machine level.
- R6: Supervisor entry gives pc_o = stvec_i and priv_o = 1, and latches scause = cause_i and sepc = epc_i. status_o equals status_i except bit 5 = status_i[priv_i], bit 8 = priv_i[0] and bit 1 = 0.
- R7: Machine entry gives pc_o = mtvec_i and priv_o = 3, and latches mcause = cause_i and mepc = epc_i. status_o equals status_i except bit 7 = status_i[priv_i], bits 12:11 = priv_i and bit 3 = 0.
- R8: The bad-address register of the handling level loads badaddr_i only when badaddr_vld_i is 1. Otherwise it keeps its value.
- R9: With trap_i low, pc_o is 0, both write strobes are low, priv_o = priv_i, status_o = status_i, and no register changes.
- R10: pc_o, priv_o, status_o and the strobes are valid in the strobe cycle itself. The latched registers show the new values right after the rising edge of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Trap strobe, one cycle per trap |
| cause_i | input | XLEN | Cause word, top bit marks an interrupt |
| epc_i | input | XLEN | PC of the trapping instruction |
| badaddr_i | input | XLEN | Faulting address |
| badaddr_vld_i | input | 1 | badaddr_i is meaningful |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 2 H, 3 M) |
| status_i | input | XLEN | Current status word |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor trap vector |
| mtvec_i | input | XLEN | Machine trap vector |
| ebreak_en_i | input | 4 | Breakpoint-to-debug enable, indexed by privilege |
| pc_o | output | XLEN | Redirect PC, 0 without trap |
| priv_we_o | output | 1 | Privilege write strobe |
| priv_o | output | 2 | New privilege |
| status_we_o | output | 1 | Status write strobe |
| status_o | output | XLEN | New status word |
| scause_o | output | XLEN | Supervisor cause register |
| sepc_o | output | XLEN | Supervisor exception PC |
| sbadaddr_o | output | XLEN | Supervisor bad-address register |
| mcause_o | output | XLEN | Machine cause register |
| mepc_o | output | XLEN | Machine exception PC |
| mbadaddr_o | output | XLEN | Machine bad-address register |
| dpc_o | output | XLEN | Debug PC |
| dbg_cause_o | output | 3 | Debug cause, 1 for a breakpoint entry |
| dbg_prv_o | output | 2 | Privilege saved on debug entry |

## Verification
Redirect PC, privilege, status and both strobes depend only on the inputs and the latched debug cause, so they are due in the strobe cycle itself. The bench drives each vector on the falling edge and compares these outputs 2 ns later, before the next rising edge. The cause, EPC, bad-address and debug registers change on that rising edge. The bench compares them with its model at the following falling edge, before it applies the next vector. Each result is therefore checked in exactly the cycle it is due.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRV_U = 2'd0,
    PRV_S = 2'd1,
    PRV_H = 2'd2,
    PRV_M = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    RT_NONE      = 3'd0,
    RT_DBG_ENTER = 3'd1,
    RT_DBG_EXC   = 3'd2,
    RT_SUP       = 3'd3,
    RT_MACH      = 3'd4
  } route_e;

  localparam int unsigned BKPT_CODE  = 3;
  localparam int unsigned DCAUSE_W   = 3;
  localparam int unsigned DCAUSE_BKP = 1;

  // status word bit positions decoded by the CSR file
  localparam int unsigned ST_SIE  = 1;
  localparam int unsigned ST_MIE  = 3;
  localparam int unsigned ST_SPIE = 5;
  localparam int unsigned ST_MPIE = 7;
  localparam int unsigned ST_SPP  = 8;
  localparam int unsigned ST_MPP  = 11;
endpackage

// File: rtl/trap_rst_sync.sv
module trap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            trap,
  input  logic [XLEN-1:0] cause,
  input  logic [1:0]      priv,
  input  logic [XLEN-1:0] medeleg,
  input  logic [XLEN-1:0] mideleg,
  input  logic [3:0]      ebreak_en,
  input  logic            dbg_active,
  output route_e          route
);
  localparam int unsigned    IDXW = $clog2(XLEN);
  localparam logic [XLEN-1:0] LIM = XLEN'(XLEN);
  localparam logic [XLEN-1:0] BKP = XLEN'(BKPT_CODE);

  logic            is_irq;
  logic [XLEN-1:0] idx;
  logic [XLEN-1:0] mask;
  logic            idx_ok;
  logic            dbit;
  logic            bkpt_div;
  logic            low_priv;

  always_comb begin
    is_irq   = cause[XLEN-1];
    idx      = is_irq ? {1'b0, cause[XLEN-2:0]} : cause;
    mask     = is_irq ? mideleg : medeleg;
    idx_ok   = idx < LIM;
    dbit     = idx_ok ? mask[idx[IDXW-1:0]] : 1'b0;
    bkpt_div = !is_irq && (cause == BKP) && ebreak_en[priv];
    low_priv = priv <= 2'(PRV_S);

    if (!trap)            route = RT_NONE;
    else if (bkpt_div)    route = RT_DBG_ENTER;
    else if (dbg_active)  route = RT_DBG_EXC;
    else if (low_priv && dbit) route = RT_SUP;
    else                  route = RT_MACH;
  end
endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] status,
  input  logic [1:0]      priv,
  input  logic            to_sup,
  output logic [XLEN-1:0] status_nxt
);
  logic cur_ie;

  always_comb begin
    cur_ie     = status[priv];
    status_nxt = status;
    if (to_sup) begin
      status_nxt[ST_SPIE] = cur_ie;
      status_nxt[ST_SPP]  = priv[0];
      status_nxt[ST_SIE]  = 1'b0;
    end else begin
      status_nxt[ST_MPIE]       = cur_ie;
      status_nxt[ST_MPP +: 2]   = priv;
      status_nxt[ST_MIE]        = 1'b0;
    end
  end
endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  route_e              route,
  input  logic [XLEN-1:0]     cause,
  input  logic [XLEN-1:0]     epc,
  input  logic [XLEN-1:0]     badaddr,
  input  logic                badaddr_vld,
  input  logic [1:0]          priv,
  output logic [XLEN-1:0]     scause_q,
  output logic [XLEN-1:0]     sepc_q,
  output logic [XLEN-1:0]     sbad_q,
  output logic [XLEN-1:0]     mcause_q,
  output logic [XLEN-1:0]     mepc_q,
  output logic [XLEN-1:0]     mbad_q,
  output logic [XLEN-1:0]     dpc_q,
  output logic [DCAUSE_W-1:0] dcause_q,
  output logic [1:0]          dprv_q
);
  logic s_en, m_en, d_en, sb_en, mb_en;

  always_comb begin
    s_en  = route == RT_SUP;
    m_en  = route == RT_MACH;
    d_en  = route == RT_DBG_ENTER;
    sb_en = s_en && badaddr_vld;
    mb_en = m_en && badaddr_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scause_q <= '0;
      sepc_q   <= '0;
      sbad_q   <= '0;
      mcause_q <= '0;
      mepc_q   <= '0;
      mbad_q   <= '0;
      dpc_q    <= '0;
      dcause_q <= '0;
      dprv_q   <= '0;
    end else begin
      if (s_en) begin
        scause_q <= cause;
        sepc_q   <= epc;
      end
      if (sb_en) sbad_q <= badaddr;
      if (m_en) begin
        mcause_q <= cause;
        mepc_q   <= epc;
      end
      if (mb_en) mbad_q <= badaddr;
      if (d_en) begin
        dpc_q    <= epc;
        dcause_q <= DCAUSE_W'(DCAUSE_BKP);
        dprv_q   <= priv;
      end
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned      XLEN          = 32,
  parameter logic [XLEN-1:0]  DBG_ROM_BASE  = 'h800,
  parameter logic [XLEN-1:0]  DBG_ROM_EXC   = 'h808
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trap_i,
  input  logic [XLEN-1:0]     cause_i,
  input  logic [XLEN-1:0]     epc_i,
  input  logic [XLEN-1:0]     badaddr_i,
  input  logic                badaddr_vld_i,
  input  logic [1:0]          priv_i,
  input  logic [XLEN-1:0]     status_i,
  input  logic [XLEN-1:0]     medeleg_i,
  input  logic [XLEN-1:0]     mideleg_i,
  input  logic [XLEN-1:0]     stvec_i,
  input  logic [XLEN-1:0]     mtvec_i,
  input  logic [3:0]          ebreak_en_i,
  output logic [XLEN-1:0]     pc_o,
  output logic                priv_we_o,
  output logic [1:0]          priv_o,
  output logic                status_we_o,
  output logic [XLEN-1:0]     status_o,
  output logic [XLEN-1:0]     scause_o,
  output logic [XLEN-1:0]     sepc_o,
  output logic [XLEN-1:0]     sbadaddr_o,
  output logic [XLEN-1:0]     mcause_o,
  output logic [XLEN-1:0]     mepc_o,
  output logic [XLEN-1:0]     mbadaddr_o,
  output logic [XLEN-1:0]     dpc_o,
  output logic [DCAUSE_W-1:0] dbg_cause_o,
  output logic [1:0]          dbg_prv_o
);
  logic            rst_q_n;
  route_e          route;
  logic [XLEN-1:0] status_nxt;

  trap_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  trap_route #(.XLEN(XLEN)) route_i (
    .trap       (trap_i),
    .cause      (cause_i),
    .priv       (priv_i),
    .medeleg    (medeleg_i),
    .mideleg    (mideleg_i),
    .ebreak_en  (ebreak_en_i),
    .dbg_active (dbg_cause_o != '0),
    .route      (route)
  );

  trap_status_upd #(.XLEN(XLEN)) status_i_upd (
    .status     (status_i),
    .priv       (priv_i),
    .to_sup     (route == RT_SUP),
    .status_nxt (status_nxt)
  );

  trap_csr_bank #(.XLEN(XLEN)) bank_i (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .route       (route),
    .cause       (cause_i),
    .epc         (epc_i),
    .badaddr     (badaddr_i),
    .badaddr_vld (badaddr_vld_i),
    .priv        (priv_i),
    .scause_q    (scause_o),
    .sepc_q      (sepc_o),
    .sbad_q      (sbadaddr_o),
    .mcause_q    (mcause_o),
    .mepc_q      (mepc_o),
    .mbad_q      (mbadaddr_o),
    .dpc_q       (dpc_o),
    .dcause_q    (dbg_cause_o),
    .dprv_q      (dbg_prv_o)
  );

  always_comb begin
    pc_o        = '0;
    priv_we_o   = 1'b0;
    priv_o      = priv_i;
    status_we_o = 1'b0;
    status_o    = status_i;
    case (route)
      RT_DBG_ENTER: begin
        pc_o      = DBG_ROM_BASE;
        priv_we_o = 1'b1;
        priv_o    = 2'(PRV_M);
      end
      RT_DBG_EXC: pc_o = DBG_ROM_EXC;
      RT_SUP: begin
        pc_o        = stvec_i;
        priv_we_o   = 1'b1;
        priv_o      = 2'(PRV_S);
        status_we_o = 1'b1;
        status_o    = status_nxt;
      end
      RT_MACH: begin
        pc_o        = mtvec_i;
        priv_we_o   = 1'b1;
        priv_o      = 2'(PRV_M);
        status_we_o = 1'b1;
        status_o    = status_nxt;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int unsigned      XLEN         = 32,
  parameter logic [XLEN-1:0]  DBG_ROM_BASE = 'h800,
  parameter logic [XLEN-1:0]  DBG_ROM_EXC  = 'h808
) (
  input logic                clk,
  input logic                rst_n,
  input logic                trap_i,
  input logic [XLEN-1:0]     cause_i,
  input logic                badaddr_vld_i,
  input logic [1:0]          priv_i,
  input logic [XLEN-1:0]     status_i,
  input logic [3:0]          ebreak_en_i,
  input logic [XLEN-1:0]     pc_o,
  input logic                priv_we_o,
  input logic [1:0]          priv_o,
  input logic                status_we_o,
  input logic [XLEN-1:0]     status_o,
  input logic [XLEN-1:0]     scause_o,
  input logic [XLEN-1:0]     sbadaddr_o,
  input logic [XLEN-1:0]     mcause_o,
  input logic [XLEN-1:0]     mbadaddr_o,
  input logic [XLEN-1:0]     dpc_o,
  input logic [DCAUSE_W-1:0] dbg_cause_o,
  input logic [1:0]          dbg_prv_o
);
  localparam logic [XLEN-1:0] BKP = XLEN'(BKPT_CODE);
  logic bkpt_hit;
  assign bkpt_hit = !cause_i[XLEN-1] && (cause_i == BKP) && ebreak_en_i[priv_i];

  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_i |-> !priv_we_o && !status_we_o && pc_o == '0);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_i |=> $stable(scause_o) && $stable(mcause_o) && $stable(dpc_o) && $stable(dbg_cause_o));

  assert_dbg_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i && bkpt_hit |-> pc_o == DBG_ROM_BASE && priv_we_o && priv_o == 2'd3 && !status_we_o);

  assert_dbg_record_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i && bkpt_hit |=> dbg_cause_o == DCAUSE_W'(DCAUSE_BKP) && dbg_prv_o == $past(priv_i));

  assert_dbg_exc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i && dbg_cause_o != '0 && !bkpt_hit |-> pc_o == DBG_ROM_EXC && !priv_we_o && !status_we_o);

  assert_high_priv_mach_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i && priv_i[1] && priv_we_o |-> priv_o == 2'd3);

  assert_sie_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_we_o && priv_o == 2'd1 |-> !status_o[ST_SIE] && status_o[ST_MIE] == status_i[ST_MIE]);

  assert_mie_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_we_o && priv_o == 2'd3 |-> !status_o[ST_MIE] && status_o[ST_SIE] == status_i[ST_SIE]);

  assert_badaddr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i && !badaddr_vld_i |=> $stable(sbadaddr_o) && $stable(mbadaddr_o));
endmodule

bind trap_entry_ctrl trap_entry_chk #(
  .XLEN(XLEN), .DBG_ROM_BASE(DBG_ROM_BASE), .DBG_ROM_EXC(DBG_ROM_EXC)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .trap_i        (trap_i),
  .cause_i       (cause_i),
  .badaddr_vld_i (badaddr_vld_i),
  .priv_i        (priv_i),
  .status_i      (status_i),
  .ebreak_en_i   (ebreak_en_i),
  .pc_o          (pc_o),
  .priv_we_o     (priv_we_o),
  .priv_o        (priv_o),
  .status_we_o   (status_we_o),
  .status_o      (status_o),
  .scause_o      (scause_o),
  .sbadaddr_o    (sbadaddr_o),
  .mcause_o      (mcause_o),
  .mbadaddr_o    (mbadaddr_o),
  .dpc_o         (dpc_o),
  .dbg_cause_o   (dbg_cause_o),
  .dbg_prv_o     (dbg_prv_o)
);

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb_top;
  localparam int unsigned XLEN = 32;
  localparam logic [31:0] DROM = 32'h0000_0800;
  localparam logic [31:0] DEXC = 32'h0000_0808;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_i = 1'b0;
  logic [31:0] cause_i = '0, epc_i = '0, badaddr_i = '0;
  logic        badaddr_vld_i = 1'b0;
  logic [1:0]  priv_i = '0;
  logic [31:0] status_i = '0, medeleg_i = '0, mideleg_i = '0, stvec_i = '0, mtvec_i = '0;
  logic [3:0]  ebreak_en_i = '0;
  logic [31:0] pc_o, status_o, scause_o, sepc_o, sbadaddr_o, mcause_o, mepc_o, mbadaddr_o, dpc_o;
  logic        priv_we_o, status_we_o;
  logic [1:0]  priv_o, dbg_prv_o;
  logic [2:0]  dbg_cause_o;

  always #4 clk = ~clk;

  trap_entry_ctrl #(.XLEN(XLEN), .DBG_ROM_BASE(DROM), .DBG_ROM_EXC(DEXC)) dut_i (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .cause_i(cause_i), .epc_i(epc_i),
    .badaddr_i(badaddr_i), .badaddr_vld_i(badaddr_vld_i), .priv_i(priv_i),
    .status_i(status_i), .medeleg_i(medeleg_i), .mideleg_i(mideleg_i),
    .stvec_i(stvec_i), .mtvec_i(mtvec_i), .ebreak_en_i(ebreak_en_i),
    .pc_o(pc_o), .priv_we_o(priv_we_o), .priv_o(priv_o), .status_we_o(status_we_o),
    .status_o(status_o), .scause_o(scause_o), .sepc_o(sepc_o), .sbadaddr_o(sbadaddr_o),
    .mcause_o(mcause_o), .mepc_o(mepc_o), .mbadaddr_o(mbadaddr_o), .dpc_o(dpc_o),
    .dbg_cause_o(dbg_cause_o), .dbg_prv_o(dbg_prv_o)
  );

  int nvec = 0;
  int nfail = 0;
  logic [31:0] m_scause, m_sepc, m_sbad, m_mcause, m_mepc, m_mbad, m_dpc;
  logic [2:0]  m_dcause;
  logic [1:0]  m_dprv;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_scause = '0; m_sepc = '0; m_sbad = '0; m_mcause = '0; m_mepc = '0;
    m_mbad = '0; m_dpc = '0; m_dcause = '0; m_dprv = '0;
  endtask

  task automatic check_regs(input string tag);
    chk(tag, "scause", scause_o, m_scause);
    chk(tag, "sepc", sepc_o, m_sepc);
    chk("R8", "sbadaddr", sbadaddr_o, m_sbad);
    chk(tag, "mcause", mcause_o, m_mcause);
    chk(tag, "mepc", mepc_o, m_mepc);
    chk("R8", "mbadaddr", mbadaddr_o, m_mbad);
    chk(tag, "dpc", dpc_o, m_dpc);
    chk(tag, "dbg_cause", 32'(dbg_cause_o), 32'(m_dcause));
    chk(tag, "dbg_prv", 32'(dbg_prv_o), 32'(m_dprv));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    trap_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
    check_regs("R1");
    chk("R1", "priv_we", 32'(priv_we_o), 0);
    chk("R1", "status_we", 32'(status_we_o), 0);
  endtask

  // Drive one vector at the falling edge; check registered state from the
  // previous vector first, then the same-cycle outputs 2 ns later.
  task automatic apply(input logic tr, input logic [31:0] cs, input logic [31:0] ep,
                       input logic [31:0] ba, input logic bv, input logic [1:0] pv,
                       input logic [31:0] st, input logic [31:0] med, input logic [31:0] mid,
                       input logic [31:0] sv, input logic [31:0] mv, input logic [3:0] ebk);
    logic        irq, dbit, bp;
    logic [31:0] idx, dl, e_pc, e_st;
    logic [1:0]  e_pv;
    logic        e_pwe, e_swe;
    int          rt;
    string       tag;
    @(negedge clk);
    check_regs("R10");
    trap_i = tr; cause_i = cs; epc_i = ep; badaddr_i = ba; badaddr_vld_i = bv;
    priv_i = pv; status_i = st; medeleg_i = med; mideleg_i = mid;
    stvec_i = sv; mtvec_i = mv; ebreak_en_i = ebk;
    #2;
    irq  = cs[31];
    idx  = irq ? {1'b0, cs[30:0]} : cs;
    dl   = irq ? mid : med;
    dbit = (idx < 32) ? dl[idx[4:0]] : 1'b0;
    bp   = !irq && cs == 32'd3 && ebk[pv];
    if (!tr) rt = 0;
    else if (bp) rt = 1;
    else if (m_dcause != 0) rt = 2;
    else if (pv <= 2'd1 && dbit) rt = 3;
    else rt = 4;
    e_pc = 0; e_pv = pv; e_pwe = 0; e_swe = 0; e_st = st;
    case (rt)
      0: tag = "R9";
      1: begin tag = "R2"; e_pc = DROM; e_pv = 2'd3; e_pwe = 1; end
      2: begin tag = "R3"; e_pc = DEXC; end
      3: begin
        tag = irq ? "R4" : "R6";
        e_pc = sv; e_pv = 2'd1; e_pwe = 1; e_swe = 1;
        e_st[5] = st[pv]; e_st[8] = pv[0]; e_st[1] = 1'b0;
      end
      default: begin
        tag = (dbit && pv > 2'd1) ? "R5" : (irq ? "R4" : "R7");
        e_pc = mv; e_pv = 2'd3; e_pwe = 1; e_swe = 1;
        e_st[7] = st[pv]; e_st[12:11] = pv; e_st[3] = 1'b0;
      end
    endcase
    chk(tag, "pc", pc_o, e_pc);
    chk(tag, "priv_we", 32'(priv_we_o), 32'(e_pwe));
    chk(tag, "priv", 32'(priv_o), 32'(e_pv));
    chk(tag, "status_we", 32'(status_we_o), 32'(e_swe));
    chk(tag, "status", status_o, e_st);
    case (rt)
      1: begin m_dpc = ep; m_dcause = 3'd1; m_dprv = pv; end
      3: begin m_scause = cs; m_sepc = ep; if (bv) m_sbad = ba; end
      4: begin m_mcause = cs; m_mepc = ep; if (bv) m_mbad = ba; end
      default: ;
    endcase
  endtask

  task automatic idle();
    apply(1'b0, 32'h5, 32'h1234, 32'hdead, 1'b1, 2'd0, 32'h0, 32'hffff_ffff,
          32'hffff_ffff, 32'h100, 32'h200, 4'hf);
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();
    idle();                                                          // R9
    // R7: U-mode exception, not delegated
    apply(1, 32'd2, 32'h4000, 32'haaaa, 1, 2'd0, 32'h1, 32'h0, 32'h0, 32'h1100, 32'h2200, 4'h0);
    // R6: U-mode exception delegated
    apply(1, 32'd2, 32'h4004, 32'hbbbb, 1, 2'd0, 32'h9, 32'h4, 32'h0, 32'h1100, 32'h2200, 4'h0);
    // R4: S-mode interrupt delegated, bad address not valid (R8)
    apply(1, 32'h8000_0005, 32'h4008, 32'hcccc, 0, 2'd1, 32'h2, 32'h0, 32'h20, 32'h1100, 32'h2200, 4'h0);
    // R5: M-mode with delegation bit set stays in M
    apply(1, 32'd2, 32'h400c, 32'hdddd, 0, 2'd3, 32'h8, 32'h4, 32'h0, 32'h1100, 32'h2200, 4'h0);
    // R5: H-mode with delegation bit set goes to M
    apply(1, 32'd2, 32'h4010, 32'heeee, 1, 2'd2, 32'h4, 32'h4, 32'h0, 32'h1100, 32'h2200, 4'h0);
    // R4: interrupt index beyond XLEN is never delegated
    apply(1, 32'h8000_0028, 32'h4014, 32'h0, 0, 2'd0, 32'h0, 32'h0, 32'hffff_ffff, 32'h1100, 32'h2200, 4'h0);
    // R4: exception index beyond XLEN
    apply(1, 32'd40, 32'h4018, 32'h0, 0, 2'd1, 32'h2, 32'hffff_ffff, 32'h0, 32'h1100, 32'h2200, 4'h0);
    // R7: breakpoint with enable clear traps normally
    apply(1, 32'd3, 32'h401c, 32'h0, 0, 2'd0, 32'h0, 32'h0, 32'h0, 32'h1100, 32'h2200, 4'h0);
    // R2: breakpoint diverted from U
    apply(1, 32'd3, 32'h4020, 32'h0, 0, 2'd0, 32'h0, 32'h8, 32'h0, 32'h1100, 32'h2200, 4'b0001);
    // R3: trap while debug cause set
    apply(1, 32'd2, 32'h4024, 32'h1111, 1, 2'd0, 32'h0, 32'h4, 32'h0, 32'h1100, 32'h2200, 4'h0);
    // R2 over R3: breakpoint from S again diverts
    apply(1, 32'd3, 32'h4028, 32'h0, 0, 2'd1, 32'h0, 32'h0, 32'h0, 32'h1100, 32'h2200, 4'b0010);
    // R3: enable for M only, hart in U
    apply(1, 32'd3, 32'h402c, 32'h0, 0, 2'd0, 32'h0, 32'h0, 32'h0, 32'h1100, 32'h2200, 4'b1000);
    idle();
    do_reset();
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r0 = $urandom, r1 = $urandom, r2 = $urandom, r3 = $urandom;
      logic [31:0] cs = r0[7] ? {r0[31], 26'd0, r1[4:0]} : {28'd0, r1[3:0]};
      apply(r2[0] | r2[1], cs, r1, r3, r2[2], r2[4:3], $urandom, $urandom,
            $urandom, $urandom, $urandom, (r2[9:5] == 0) ? r0[11:8] : 4'h0);
      if (i == 300) do_reset();
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule